// File: doc/BRIEF.md
# Lane-checked control/status register bank

This block is a small bank of control and status registers on a plain 32-bit request/response bus. Each cycle a requester presents a byte address, write data, a read strobe, a write strobe and a 4-bit byte-lane enable. The bank answers in the same cycle with read data, a ready flag and an error flag. Each register is made of fields. A field has a fixed bit span and is readable, writable or both. Writes change only the writable field bits inside the enabled byte lanes. Reads return the readable field bits in place, with every other bit at zero.

The error flag reports a request in which nothing could have happened. It rises only when no enabled byte lane reaches a field that is open to the requested direction. A request that is only partly accessible is therefore answered without an error. An address that matches no register is answered with zero data and the error flag set. Ready is then raised only if a strobe was present. The bank also brings out the raw storage of every register, so that the surrounding hardware can read it.

Top module: `csr_lane_bank`

## Requirements
- R1: On a clock edge with `rst_n` low, every field goes to its reset value and every bit outside a field goes to zero. The reset values are: en 0, mode 2, rev 3, thr 0x10, ver 0x3C, id 0xC7, kick 0, arg 0, lo 0, hi 0x5A.
- R2: When the address matches a register, `rsp_rdy` is 1 in the same cycle, whatever the strobes are.
- R3: Read data for a matched register holds each readable field at its own bit span, and all other bits are zero. The layout is as follows.
  - CTRL at 0x00 holds en[0] (read/write), mode[5:4] (read/write), rev[9:8] (read-only) and thr[23:16] (read/write).
  - STAT at 0x04 holds ver[15:8] and id[31:24], both read-only.
  - CMD at 0x08 holds kick[15:0] and arg[27:24], both write-only.
  - Each SCR element holds lo[11:0] and hi[27:20], both read/write.
- R4: A write (`req_wr_vld`=1) to a matched register loads `req_wdata` into exactly the writable field bits whose byte lane has its `req_be` bit set. Byte lane n covers bits 8n+7..8n. All other storage bits keep their values.
- R5: A bus write never changes a read-only field. In particular, STAT storage holds its reset value forever.
- R6: For a matched register, `rsp_err` = NOT((`req_rd_vld` AND some enabled lane lies in the byte span of a readable field) OR (`req_wr_vld` AND some enabled lane lies in the byte span of a writable field)). A field's byte span runs from the lane of its LSB to the lane of its MSB. A request with no strobe therefore reports an error.
- R7: A register with no readable field (CMD) reports an error on every read-only request. A register with no writable field (STAT) reports an error on every write-only request.
- R8: For an address that matches no register, `rsp_data` is 0, `rsp_err` is 1 and `rsp_rdy` equals `req_rd_vld` OR `req_wr_vld`. No storage changes.
- R9: SCR element i (0 ≤ i < SCR_COUNT) is decoded at byte address 0x10 + 4·i. Each element has its own storage.
- R10: The decoder compares all 32 address bits. Misaligned addresses, addresses past the array and addresses that differ only in upper bits all count as unmatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| req_wr_vld | input | 1 | Write strobe |
| req_rd_vld | input | 1 | Read strobe |
| req_be | input | 4 | Byte-lane enable, bit n selects bits 8n+7..8n |
| rsp_data | output | 32 | Read data, combinational |
| rsp_rdy | output | 1 | Response ready, combinational |
| rsp_err | output | 1 | Response error, combinational |
| reg_q_flat | output | (3+SCR_COUNT)*32 | Raw storage of all registers; register k sits at bits 32k+31..32k, in the order CTRL, STAT, CMD, SCR[0..] |

## Verification
Every mapped register is driven with all sixteen byte-lane patterns under each of the four strobe combinations: none, read only, write only, and both. This separates lanes that reach only a read-only field (CTRL lane 1) and lanes that reach no field at all (CTRL lane 3) from lanes that reach a writable field. It also separates a whole-register direction failure (STAT writes, CMD reads) from the success of a mixed request. The write data changes with the lane pattern and the register. A wrong lane mask, a write that leaks into a read-only field, or a write that lands in the wrong array element therefore shows up in the raw storage outputs. Unmatched addresses are tried in several forms, each under every strobe combination: a gap in the map, an address just past the array, a misaligned address, and addresses that alias in the upper bits.

// File: rtl/csr_lane_pkg.sv
package csr_lane_pkg;

  localparam int DW     = 32;
  localparam int AW     = 32;
  localparam int LANES  = DW / 8;
  localparam int NFIXED = 3;
  localparam int NFIELD = 10;

  localparam logic [AW-1:0] SCR_BASE   = 32'h0000_0010;
  localparam logic [AW-1:0] REG_STRIDE = 32'd4;

  typedef enum logic [1:0] {
    K_CTRL = 2'd0,
    K_STAT = 2'd1,
    K_CMD  = 2'd2,
    K_SCR  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e       kind;
    logic [4:0]      lsb;
    logic [4:0]      msb;
    logic            rd;
    logic            wr;
    logic [DW-1:0]   rst;
  } field_desc_t;

  // Each field: owner register kind, bit span, access, reset value (right aligned)
  localparam field_desc_t FIELD_TAB [NFIELD] = '{
    '{K_CTRL, 5'd0,  5'd0,  1'b1, 1'b1, 32'h0000_0000},
    '{K_CTRL, 5'd4,  5'd5,  1'b1, 1'b1, 32'h0000_0002},
    '{K_CTRL, 5'd8,  5'd9,  1'b1, 1'b0, 32'h0000_0003},
    '{K_CTRL, 5'd16, 5'd23, 1'b1, 1'b1, 32'h0000_0010},
    '{K_STAT, 5'd8,  5'd15, 1'b1, 1'b0, 32'h0000_003C},
    '{K_STAT, 5'd24, 5'd31, 1'b1, 1'b0, 32'h0000_00C7},
    '{K_CMD,  5'd0,  5'd15, 1'b0, 1'b1, 32'h0000_0000},
    '{K_CMD,  5'd24, 5'd27, 1'b0, 1'b1, 32'h0000_0000},
    '{K_SCR,  5'd0,  5'd11, 1'b1, 1'b1, 32'h0000_0000},
    '{K_SCR,  5'd20, 5'd27, 1'b1, 1'b1, 32'h0000_005A}
  };

  function automatic logic [DW-1:0] span_mask(int lo, int hi);
    logic [DW-1:0] m;
    m = '0;
    for (int b = 0; b < DW; b++)
      if (b >= lo && b <= hi) m[b] = 1'b1;
    return m;
  endfunction

  function automatic bit field_open(int f, bit want_wr);
    return want_wr ? bit'(FIELD_TAB[f].wr) : bit'(FIELD_TAB[f].rd);
  endfunction

  // Bits covered by fields of kind k that allow the given direction
  function automatic logic [DW-1:0] kind_mask(reg_kind_e k, bit want_wr);
    logic [DW-1:0] m;
    m = '0;
    for (int f = 0; f < NFIELD; f++)
      if (FIELD_TAB[f].kind == k && field_open(f, want_wr))
        m |= span_mask(int'(FIELD_TAB[f].lsb), int'(FIELD_TAB[f].msb));
    return m;
  endfunction

  // Byte lanes from the LSB lane to the MSB lane of each open field
  function automatic logic [LANES-1:0] kind_lanes(reg_kind_e k, bit want_wr);
    logic [LANES-1:0] l;
    l = '0;
    for (int f = 0; f < NFIELD; f++)
      if (FIELD_TAB[f].kind == k && field_open(f, want_wr))
        for (int b = 0; b < LANES; b++)
          if (b >= int'(FIELD_TAB[f].lsb) / 8 && b <= int'(FIELD_TAB[f].msb) / 8)
            l[b] = 1'b1;
    return l;
  endfunction

  function automatic logic [DW-1:0] kind_reset(reg_kind_e k);
    logic [DW-1:0] v;
    v = '0;
    for (int f = 0; f < NFIELD; f++)
      if (FIELD_TAB[f].kind == k)
        v |= (FIELD_TAB[f].rst << FIELD_TAB[f].lsb)
             & span_mask(int'(FIELD_TAB[f].lsb), int'(FIELD_TAB[f].msb));
    return v;
  endfunction

  function automatic logic [DW-1:0] lane_expand(logic [LANES-1:0] be);
    logic [DW-1:0] m;
    for (int l = 0; l < LANES; l++) m[l*8 +: 8] = {8{be[l]}};
    return m;
  endfunction

  function automatic reg_kind_e kind_of(int idx);
    case (idx)
      0:       return K_CTRL;
      1:       return K_STAT;
      2:       return K_CMD;
      default: return K_SCR;
    endcase
  endfunction

  function automatic logic [AW-1:0] addr_of(int idx);
    if (idx < NFIXED) return AW'(idx) * REG_STRIDE;
    return SCR_BASE + AW'(idx - NFIXED) * REG_STRIDE;
  endfunction

endpackage

// File: rtl/csr_field_store.sv
module csr_field_store
  import csr_lane_pkg::*;
#(
  parameter logic [DW-1:0] WMASK = '0,
  parameter logic [DW-1:0] RSTV  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] be,
  output logic [DW-1:0]    q
);

  logic [DW-1:0] upd_mask;

  assign upd_mask = wr_en ? (WMASK & lane_expand(be)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RSTV;
    else        q <= (q & ~upd_mask) | (wdata & upd_mask);
  end

endmodule

// File: rtl/csr_resp_unit.sv
module csr_resp_unit
  import csr_lane_pkg::*;
#(
  parameter logic [DW-1:0]    RMASK  = '0,
  parameter logic [LANES-1:0] RLANES = '0,
  parameter logic [LANES-1:0] WLANES = '0
) (
  input  logic [DW-1:0]    q,
  input  logic             rd_vld,
  input  logic             wr_vld,
  input  logic [LANES-1:0] be,
  output logic [DW-1:0]    rdata,
  output logic             rd_ok,
  output logic             wr_ok,
  output logic             err
);

  assign rdata = q & RMASK;
  assign rd_ok = rd_vld && (|(be & RLANES));
  assign wr_ok = wr_vld && (|(be & WLANES));
  assign err   = !(rd_ok || wr_ok);

endmodule

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_lane_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] hit,
  output logic            any_hit
);

  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    assign hit[i] = (addr == addr_of(i));
  end

  assign any_hit = |hit;

endmodule

// File: rtl/csr_lane_bank.sv
module csr_lane_bank
  import csr_lane_pkg::*;
#(
  parameter int SCR_COUNT = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [AW-1:0]                     req_addr,
  input  logic [DW-1:0]                     req_wdata,
  input  logic                              req_wr_vld,
  input  logic                              req_rd_vld,
  input  logic [LANES-1:0]                  req_be,
  output logic [DW-1:0]                     rsp_data,
  output logic                              rsp_rdy,
  output logic                              rsp_err,
  output logic [(NFIXED+SCR_COUNT)*DW-1:0]  reg_q_flat
);

  localparam int NREG = NFIXED + SCR_COUNT;

  logic [NREG-1:0] dec_hit;
  logic            any_hit;
  logic [NREG-1:0] wr_fire;
  logic [NREG-1:0] err_vec;
  logic [NREG-1:0] rd_ok_vec;
  logic [NREG-1:0] wr_ok_vec;
  logic [DW-1:0]   q_arr     [NREG];
  logic [DW-1:0]   rdata_arr [NREG];
  logic [DW-1:0]   sel_data;
  logic            sel_err;

  csr_addr_decode #(.NREG(NREG)) u_dec (
    .addr    (req_addr),
    .hit     (dec_hit),
    .any_hit (any_hit)
  );

  assign wr_fire = dec_hit & {NREG{req_wr_vld}};

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam reg_kind_e KIND = kind_of(i);

    csr_field_store #(
      .WMASK (kind_mask(KIND, 1'b1)),
      .RSTV  (kind_reset(KIND))
    ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_fire[i]),
      .wdata (req_wdata),
      .be    (req_be),
      .q     (q_arr[i])
    );

    csr_resp_unit #(
      .RMASK  (kind_mask(KIND, 1'b0)),
      .RLANES (kind_lanes(KIND, 1'b0)),
      .WLANES (kind_lanes(KIND, 1'b1))
    ) u_resp (
      .q      (q_arr[i]),
      .rd_vld (req_rd_vld),
      .wr_vld (req_wr_vld),
      .be     (req_be),
      .rdata  (rdata_arr[i]),
      .rd_ok  (rd_ok_vec[i]),
      .wr_ok  (wr_ok_vec[i]),
      .err    (err_vec[i])
    );

    assign reg_q_flat[i*DW +: DW] = q_arr[i];
  end

  // One-hot select by OR reduction over matched entries
  always_comb begin
    sel_data = '0;
    sel_err  = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (dec_hit[i]) begin
        sel_data = sel_data | rdata_arr[i];
        sel_err  = sel_err | err_vec[i];
      end
    end
  end

  always_comb begin
    if (any_hit) begin
      rsp_data = sel_data;
      rsp_err  = sel_err;
      rsp_rdy  = 1'b1;
    end else begin
      rsp_data = '0;
      rsp_err  = 1'b1;
      rsp_rdy  = req_rd_vld || req_wr_vld;
    end
  end

endmodule

// File: rtl/csr_lane_bank_chk.sv
module csr_lane_bank_chk
  import csr_lane_pkg::*;
#(
  parameter int NREG = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_rd_vld,
  input logic                 req_wr_vld,
  input logic [DW-1:0]        rsp_data,
  input logic                 rsp_rdy,
  input logic                 rsp_err,
  input logic [NREG*DW-1:0]   reg_q_flat,
  input logic [NREG-1:0]      dec_hit,
  input logic                 any_hit
);

  p_match_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> rsp_rdy);

  p_ctrl_gaps_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit[0] |-> ((rsp_data & ~kind_mask(K_CTRL, 1'b0)) == '0));

  p_stat_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(reg_q_flat[DW +: DW]));

  p_err_no_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> $stable(reg_q_flat));

  p_cmd_read_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hit[2] && !req_wr_vld) |-> rsp_err);

  p_unmapped_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (rsp_err && rsp_data == '0 && rsp_rdy == (req_rd_vld || req_wr_vld)));

  p_decode_unique_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_hit));

endmodule

bind csr_lane_bank csr_lane_bank_chk #(.NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_rd_vld (req_rd_vld),
  .req_wr_vld (req_wr_vld),
  .rsp_data   (rsp_data),
  .rsp_rdy    (rsp_rdy),
  .rsp_err    (rsp_err),
  .reg_q_flat (reg_q_flat),
  .dec_hit    (dec_hit),
  .any_hit    (any_hit)
);

// File: tb/csr_lane_bank_tb_top.sv
module csr_lane_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SCR_N      = 4;
  localparam int NR         = 3 + SCR_N;
  localparam int NF         = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [31:0]       req_addr;
  logic [31:0]       req_wdata;
  logic              req_wr_vld;
  logic              req_rd_vld;
  logic [3:0]        req_be;
  logic [31:0]       rsp_data;
  logic              rsp_rdy;
  logic              rsp_err;
  logic [NR*32-1:0]  reg_q_flat;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  // Bench copy of the field layout: kind 0 CTRL, 1 STAT, 2 CMD, 3 SCR
  int          f_kind [NF] = '{0, 0, 0, 0, 1, 1, 2, 2, 3, 3};
  int          f_lsb  [NF] = '{0, 4, 8, 16, 8, 24, 0, 24, 0, 20};
  int          f_msb  [NF] = '{0, 5, 9, 23, 15, 31, 15, 27, 11, 27};
  bit          f_rd   [NF] = '{1, 1, 1, 1, 1, 1, 0, 0, 1, 1};
  bit          f_wr   [NF] = '{1, 1, 0, 1, 0, 0, 1, 1, 1, 1};
  logic [31:0] f_rst  [NF] = '{32'h0, 32'h2, 32'h3, 32'h10, 32'h3C, 32'hC7,
                               32'h0, 32'h0, 32'h0, 32'h5A};

  logic [31:0] model [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_lane_bank #(.SCR_COUNT(SCR_N)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_wr_vld (req_wr_vld),
    .req_rd_vld (req_rd_vld),
    .req_be     (req_be),
    .rsp_data   (rsp_data),
    .rsp_rdy    (rsp_rdy),
    .rsp_err    (rsp_err),
    .reg_q_flat (reg_q_flat)
  );

  function automatic int kind_of(int r);
    return (r < 3) ? r : 3;
  endfunction

  function automatic logic [31:0] addr_of(int r);
    return (r < 3) ? 32'(4 * r) : 32'(16 + 4 * (r - 3));
  endfunction

  function automatic logic [31:0] acc_mask(int k, bit wr);
    logic [31:0] m = '0;
    for (int f = 0; f < NF; f++)
      if (f_kind[f] == k && (wr ? f_wr[f] : f_rd[f]))
        for (int b = f_lsb[f]; b <= f_msb[f]; b++) m[b] = 1'b1;
    return m;
  endfunction

  // Does any enabled lane reach a bit of an open field
  function automatic bit lane_reach(int k, bit wr, logic [3:0] be);
    logic [31:0] m = acc_mask(k, wr);
    for (int b = 0; b < 32; b++)
      if (m[b] && be[b / 8]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] reset_word(int k);
    logic [31:0] w = '0;
    for (int f = 0; f < NF; f++)
      if (f_kind[f] == k)
        for (int b = f_lsb[f]; b <= f_msb[f]; b++) w[b] = f_rst[f][b - f_lsb[f]];
    return w;
  endfunction

  function automatic logic [31:0] lanes_to_bits(logic [3:0] be);
    logic [31:0] m = '0;
    for (int b = 0; b < 32; b++) m[b] = be[b / 8];
    return m;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_storage(string req);
    for (int i = 0; i < NR; i++)
      chk(req, $sformatf("storage reg %0d", i), reg_q_flat[i*32 +: 32], model[i]);
  endtask

  // One request; r is the register index or -1 for an unmatched address
  task automatic access(logic [31:0] addr, int r, bit rv, bit wv,
                        logic [3:0] be, logic [31:0] wd);
    int          k;
    bit          exp_err;
    bit          exp_rdy;
    logic [31:0] exp_data;
    logic [31:0] wm;
    string       etag;
    string       stag;
    @(negedge clk);
    req_addr   = addr;
    req_rd_vld = rv;
    req_wr_vld = wv;
    req_be     = be;
    req_wdata  = wd;
    #1;
    if (r >= 0) begin
      k        = kind_of(r);
      exp_rdy  = 1'b1;
      exp_err  = !((rv && lane_reach(k, 1'b0, be)) || (wv && lane_reach(k, 1'b1, be)));
      exp_data = model[r] & acc_mask(k, 1'b0);
      if ((k == 1 && wv && !rv) || (k == 2 && rv && !wv)) etag = "R7";
      else etag = "R6";
      chk("R3", "read data", rsp_data, exp_data);
      chk("R2", "ready", 32'(rsp_rdy), 32'(exp_rdy));
      chk(etag, "error", 32'(rsp_err), 32'(exp_err));
    end else begin
      k = -1;
      chk("R8", "unmatched data", rsp_data, 32'h0);
      chk("R8", "unmatched ready", 32'(rsp_rdy), 32'(rv || wv));
      chk("R10", "unmatched error", 32'(rsp_err), 32'h1);
    end
    @(posedge clk);
    if (r >= 0 && wv) begin
      wm       = acc_mask(k, 1'b1) & lanes_to_bits(be);
      model[r] = (model[r] & ~wm) | (wd & wm);
    end
    #1;
    req_rd_vld = 1'b0;
    req_wr_vld = 1'b0;
    if (r < 0)        stag = "R8";
    else if (k == 1)  stag = "R5";
    else if (k == 3)  stag = "R9";
    else              stag = "R4";
    check_storage(stag);
  endtask

  initial begin
    rst_n      = 1'b0;
    req_addr   = '0;
    req_wdata  = '0;
    req_wr_vld = 1'b0;
    req_rd_vld = 1'b0;
    req_be     = '0;
    for (int i = 0; i < NR; i++) model[i] = reset_word(kind_of(i));
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state of every register
    for (int i = 0; i < NR; i++)
      chk("R1", $sformatf("reset reg %0d", i), reg_q_flat[i*32 +: 32], model[i]);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NR; i++) access(addr_of(i), i, 1'b1, 1'b0, 4'hF, 32'h0);

    // Exhaustive sweep: every register, lane pattern and strobe combination
    for (int r = 0; r < NR; r++)
      for (int be = 0; be < 16; be++)
        for (int m = 0; m < 4; m++)
          access(addr_of(r), r, m[0], m[1], 4'(be),
                 32'hA5C3_96F1 ^ (32'(be) * 32'h0101_0101) ^ (32'(r) << 7) ^ (32'(m) << 13));

    // Unmatched addresses, R8 and R10
    begin
      logic [31:0] bad [5] = '{32'h0000_000C, 32'h0000_0020, 32'h0000_0001,
                               32'h1000_0004, 32'hFFFF_FFF0};
      for (int a = 0; a < 5; a++)
        for (int m = 0; m < 4; m++)
          access(bad[a], -1, m[0], m[1], 4'hF, 32'hFFFF_FFFF);
    end

    // Final read-back of everything
    for (int i = 0; i < NR; i++) access(addr_of(i), i, 1'b1, 1'b0, 4'hF, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule